// File: doc/BRIEF.md
# DSI Video-Mode Line Sequencer

This block paces a non-burst DSI video stream in byte-clock cycles. Software sets the vertical line counts, the horizontal segment lengths in bytes, two line-duration values and a framing mode. The block then walks each frame line by line and each line segment by segment. It reports the current segment as a code, gives one-cycle strobes at frame, line and sync boundaries, and raises a low-power request whenever the link may leave high speed. A downstream packet builder uses these outputs to decide which packet or blanking payload to send on each cycle.

Two framings are supported. Pulse framing sends sync-start and sync-end packets around a sync-active blanking payload. Event framing sends only the sync-start event and lets the link drop to low power once the useful content of a line has gone out. The horizontal byte counts are programmed with the fixed packet overheads already removed. The block adds those overheads back only as single-cycle sync slots, so the segments follow one another with no gap.

Top module: `dsi_line_seq`

## Requirements
- R1: After reset, and for as long as `en_i` is low, the block is idle: `seg_o`=0, `lp_req_o`=1 and every strobe is low. The first cycle after `en_i` is sampled high is cycle 0 of a frame. In that cycle both `frame_start_o` and `line_start_o` are 1.
- R2: A frame's lines run through the vertical phases in this order: sync (`vphase_o`=0), back porch (1), active (2), front porch (3). Each phase lasts its programmed line count, and a phase with a count of zero is skipped.
- R3: `line_start_o` is high for exactly the first cycle of every line. `line_idx_o` is 0 on the first line and rises by one on each following line. A line in the active phase lasts `line_len_i` cycles, and every other line lasts `blank_len_i` cycles.
- R4: In pulse mode an active line is laid out as follows, with byte offset b counted from line start: b=0 sync start (`seg_o`=1), then hsa bytes of sync-active blanking (2), one cycle of sync end (3), hbp bytes of back porch (4), hact bytes of active data (5), and hfp bytes of front porch (6). Any cycles left in the line are high-speed blanking fill (7).
- R5: In event mode an active line is laid out as follows: sync start (1) at b=0, then hbp bytes of back porch (4), then hact bytes of active data (5). The line has no sync-active or sync-end slot, and low power (0) holds for the rest of the line.
- R6: In pulse mode a sync, back-porch or high-speed front-porch line has the layout sync start, sync-active, sync end, followed by high-speed blanking fill (7) until the line ends.
- R7: In pulse mode a front-porch line whose index within the front porch is at or above `fp_hs_lines_i` is low power (0) for its whole length and carries no sync.
- R8: In event mode every line outside the active phase is sync start (1) at b=0 followed by low power (0).
- R9: `act_o` is high only while the active-data segment runs, and only on lines in the active phase.
- R10: The mode bit and all timing inputs are captured at the first cycle of a frame. Any change to them during a frame takes effect only from the next frame.
- R11: `en_i` is sampled on the last cycle of each frame. If it is high, the next frame starts at once. If it is low, the block returns to idle and starts again one cycle after `en_i` is next seen high.
- R12: `sync_start_o` is high exactly when `seg_o`=1, `sync_end_o` exactly when `seg_o`=3, and `lp_req_o` exactly when `seg_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run request, sampled at frame boundaries |
| pulse_mode_i | input | 1 | 1 selects pulse framing, 0 selects event framing |
| vsa_lines_i | input | LINE_W | Sync phase line count |
| vbp_lines_i | input | LINE_W | Back-porch phase line count |
| vact_lines_i | input | LINE_W | Active phase line count |
| vfp_lines_i | input | LINE_W | Front-porch phase line count |
| fp_hs_lines_i | input | LINE_W | Front-porch lines sent in high speed (pulse mode) |
| hsa_bytes_i | input | BYTE_W | Sync-active blanking bytes, overhead removed |
| hbp_bytes_i | input | BYTE_W | Back-porch bytes, overhead removed |
| hact_bytes_i | input | BYTE_W | Active data bytes |
| hfp_bytes_i | input | BYTE_W | Front-porch bytes, overhead removed |
| line_len_i | input | BYTE_W | Duration of an active line in cycles |
| blank_len_i | input | BYTE_W | Duration of a line with no active data in cycles |
| frame_start_o | output | 1 | First cycle of a frame |
| line_start_o | output | 1 | First cycle of a line |
| sync_start_o | output | 1 | Sync-start slot |
| sync_end_o | output | 1 | Sync-end slot |
| act_o | output | 1 | Active data window |
| lp_req_o | output | 1 | Low-power permitted |
| seg_o | output | 3 | Current segment code |
| vphase_o | output | 2 | Current vertical phase |
| line_idx_o | output | LINE_W+2 | Line number within the frame |
| byte_idx_o | output | BYTE_W | Cycle offset within the line |

## Verification
The bound checker watches the invariants that must hold on every cycle. A frame start always coincides with a line start. A line opens with either a sync-start slot or low power. Sync end follows sync-active or sync start. Active data begins only after a back porch or a sync slot, and occurs only in the active phase. The line index steps by one, and the vertical phase never moves backward within a frame. Only the bench's scenarios can show that segment lengths and line durations match the programmed values, that the two framings differ in layout, that a zero-count phase is skipped, that settings changed mid-frame are deferred to the next frame, and that the block stops and restarts on `en_i`.

// File: rtl/dsi_seq_pkg.sv
package dsi_seq_pkg;

  typedef enum logic [2:0] {
    SEG_LP  = 3'd0,
    SEG_SS  = 3'd1,
    SEG_SA  = 3'd2,
    SEG_SE  = 3'd3,
    SEG_BP  = 3'd4,
    SEG_ACT = 3'd5,
    SEG_FP  = 3'd6,
    SEG_BLK = 3'd7
  } seg_e;

  typedef enum logic [1:0] {
    VPH_SYNC  = 2'd0,
    VPH_BACK  = 2'd1,
    VPH_ACT   = 2'd2,
    VPH_FRONT = 2'd3
  } vph_e;

  localparam int NUM_VPH = 4;

endpackage

// File: rtl/dsi_seq_cfg.sv
module dsi_seq_cfg
  import dsi_seq_pkg::*;
#(
  parameter int LINE_W = 12,
  parameter int BYTE_W = 16,
  localparam int BW    = BYTE_W + 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             load_i,
  input  logic                             pulse_i,
  input  logic [NUM_VPH-1:0][LINE_W-1:0]   vcnt_i,
  input  logic [LINE_W-1:0]                fp_hs_i,
  input  logic [BYTE_W-1:0]                hsa_i,
  input  logic [BYTE_W-1:0]                hbp_i,
  input  logic [BYTE_W-1:0]                hact_i,
  input  logic [BYTE_W-1:0]                hfp_i,
  input  logic [BYTE_W-1:0]                line_len_i,
  input  logic [BYTE_W-1:0]                blank_len_i,
  output logic                             pulse_o,
  output logic [NUM_VPH-1:0][LINE_W-1:0]   vcnt_o,
  output logic [LINE_W-1:0]                fp_hs_o,
  output logic [BYTE_W-1:0]                line_len_o,
  output logic [BYTE_W-1:0]                blank_len_o,
  output logic [BW-1:0]                    e_sa_o,
  output logic [BW-1:0]                    e_se_o,
  output logic [BW-1:0]                    e_bp_o,
  output logic [BW-1:0]                    e_act_o,
  output logic [BW-1:0]                    e_fp_o
);

  logic [BW-1:0] sa_d, se_d, bp_d, act_d, fp_d;

  // segment end offsets; event framing collapses sync-active and sync-end
  always_comb begin
    sa_d  = pulse_i ? BW'(hsa_i) + BW'(1) : BW'(1);
    se_d  = pulse_i ? sa_d + BW'(1) : BW'(1);
    bp_d  = se_d + BW'(hbp_i);
    act_d = bp_d + BW'(hact_i);
    fp_d  = act_d + BW'(hfp_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_o     <= 1'b0;
      vcnt_o      <= '0;
      fp_hs_o     <= '0;
      line_len_o  <= '0;
      blank_len_o <= '0;
      e_sa_o      <= '0;
      e_se_o      <= '0;
      e_bp_o      <= '0;
      e_act_o     <= '0;
      e_fp_o      <= '0;
    end else if (load_i) begin
      pulse_o     <= pulse_i;
      vcnt_o      <= vcnt_i;
      fp_hs_o     <= fp_hs_i;
      line_len_o  <= line_len_i;
      blank_len_o <= blank_len_i;
      e_sa_o      <= sa_d;
      e_se_o      <= se_d;
      e_bp_o      <= bp_d;
      e_act_o     <= act_d;
      e_fp_o      <= fp_d;
    end
  end

endmodule

// File: rtl/dsi_seq_vert.sv
module dsi_seq_vert
  import dsi_seq_pkg::*;
#(
  parameter int LINE_W = 12,
  localparam int IDX_W = LINE_W + 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  vph_e                           start_ph_i,
  input  logic                           adv_i,
  input  logic [NUM_VPH-1:0][LINE_W-1:0] vcnt_i,
  output vph_e                           vph_o,
  output logic [LINE_W-1:0]              vline_o,
  output logic [IDX_W-1:0]               line_idx_o,
  output logic                           last_o
);

  vph_e              vph_q;
  logic [LINE_W-1:0] vline_q;
  logic [IDX_W-1:0]  idx_q;
  vph_e              nxt_ph;
  logic              nxt_found;
  logic              ph_done;

  // nearest later phase with a nonzero count
  always_comb begin
    nxt_found = 1'b0;
    nxt_ph    = vph_q;
    for (int k = NUM_VPH - 1; k >= 0; k--) begin
      if (k > int'(vph_q) && vcnt_i[k] != '0) begin
        nxt_found = 1'b1;
        nxt_ph    = vph_e'(k[1:0]);
      end
    end
  end

  assign ph_done = ({1'b0, vline_q} + (LINE_W+1)'(1)) >= {1'b0, vcnt_i[vph_q]};
  assign last_o  = ph_done && !nxt_found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vph_q   <= VPH_SYNC;
      vline_q <= '0;
      idx_q   <= '0;
    end else if (start_i) begin
      vph_q   <= start_ph_i;
      vline_q <= '0;
      idx_q   <= '0;
    end else if (adv_i) begin
      idx_q <= idx_q + IDX_W'(1);
      if (!ph_done) begin
        vline_q <= vline_q + LINE_W'(1);
      end else if (nxt_found) begin
        vph_q   <= nxt_ph;
        vline_q <= '0;
      end
    end
  end

  assign vph_o      = vph_q;
  assign vline_o    = vline_q;
  assign line_idx_o = idx_q;

endmodule

// File: rtl/dsi_seq_hseg.sv
module dsi_seq_hseg
  import dsi_seq_pkg::*;
#(
  parameter int BYTE_W = 16,
  localparam int BW    = BYTE_W + 3
) (
  input  logic              run_i,
  input  logic              pulse_i,
  input  logic              act_line_i,
  input  logic              lp_line_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BW-1:0]     e_sa_i,
  input  logic [BW-1:0]     e_se_i,
  input  logic [BW-1:0]     e_bp_i,
  input  logic [BW-1:0]     e_act_i,
  input  logic [BW-1:0]     e_fp_i,
  output seg_e              seg_o
);

  logic [BW-1:0] b;
  assign b = BW'(byte_i);

  always_comb begin
    if (!run_i || lp_line_i)  seg_o = SEG_LP;
    else if (b == '0)         seg_o = SEG_SS;
    else if (b < e_sa_i)      seg_o = SEG_SA;
    else if (b < e_se_i)      seg_o = SEG_SE;
    else if (!act_line_i)     seg_o = pulse_i ? SEG_BLK : SEG_LP;
    else if (b < e_bp_i)      seg_o = SEG_BP;
    else if (b < e_act_i)     seg_o = SEG_ACT;
    else if (!pulse_i)        seg_o = SEG_LP;
    else if (b < e_fp_i)      seg_o = SEG_FP;
    else                      seg_o = SEG_BLK;
  end

endmodule

// File: rtl/dsi_line_seq.sv
module dsi_line_seq
  import dsi_seq_pkg::*;
#(
  parameter int LINE_W = 12,
  parameter int BYTE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              pulse_mode_i,
  input  logic [LINE_W-1:0] vsa_lines_i,
  input  logic [LINE_W-1:0] vbp_lines_i,
  input  logic [LINE_W-1:0] vact_lines_i,
  input  logic [LINE_W-1:0] vfp_lines_i,
  input  logic [LINE_W-1:0] fp_hs_lines_i,
  input  logic [BYTE_W-1:0] hsa_bytes_i,
  input  logic [BYTE_W-1:0] hbp_bytes_i,
  input  logic [BYTE_W-1:0] hact_bytes_i,
  input  logic [BYTE_W-1:0] hfp_bytes_i,
  input  logic [BYTE_W-1:0] line_len_i,
  input  logic [BYTE_W-1:0] blank_len_i,
  output logic              frame_start_o,
  output logic              line_start_o,
  output logic              sync_start_o,
  output logic              sync_end_o,
  output logic              act_o,
  output logic              lp_req_o,
  output logic [2:0]        seg_o,
  output logic [1:0]        vphase_o,
  output logic [LINE_W+1:0] line_idx_o,
  output logic [BYTE_W-1:0] byte_idx_o
);

  localparam int IDX_W = LINE_W + 2;
  localparam int BW    = BYTE_W + 3;

  logic                           run_q, fs_q;
  logic [BYTE_W-1:0]              byte_q;
  logic [NUM_VPH-1:0][LINE_W-1:0] raw_cnt;
  vph_e                           first_ph;

  logic                           c_pulse;
  logic [NUM_VPH-1:0][LINE_W-1:0] c_vcnt;
  logic [LINE_W-1:0]              c_fp_hs;
  logic [BYTE_W-1:0]              c_line_len, c_blank_len;
  logic [BW-1:0]                  c_e_sa, c_e_se, c_e_bp, c_e_act, c_e_fp;

  vph_e                           vph;
  logic [LINE_W-1:0]              vline;
  logic [IDX_W-1:0]               line_idx;
  logic                           v_last;

  logic [BYTE_W-1:0]              dur;
  logic                           line_end, frame_end, load, adv;
  logic                           act_line, lp_line;
  seg_e                           seg;

  assign raw_cnt = {vfp_lines_i, vact_lines_i, vbp_lines_i, vsa_lines_i};

  // first nonempty phase of the frame about to start
  always_comb begin
    first_ph = VPH_SYNC;
    for (int k = NUM_VPH - 1; k >= 0; k--) begin
      if (raw_cnt[k] != '0) first_ph = vph_e'(k[1:0]);
    end
  end

  assign dur       = (vph == VPH_ACT) ? c_line_len : c_blank_len;
  assign line_end  = run_q && (({1'b0, byte_q} + (BYTE_W+1)'(1)) >= {1'b0, dur});
  assign frame_end = line_end && v_last;
  assign load      = en_i && (!run_q || frame_end);
  assign adv       = line_end && !v_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      fs_q   <= 1'b0;
      byte_q <= '0;
    end else begin
      fs_q <= load;
      if (load) begin
        run_q  <= 1'b1;
        byte_q <= '0;
      end else if (frame_end) begin
        run_q  <= 1'b0;
        byte_q <= '0;
      end else if (line_end) begin
        byte_q <= '0;
      end else if (run_q) begin
        byte_q <= byte_q + BYTE_W'(1);
      end
    end
  end

  dsi_seq_cfg #(.LINE_W(LINE_W), .BYTE_W(BYTE_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .pulse_i     (pulse_mode_i),
    .vcnt_i      (raw_cnt),
    .fp_hs_i     (fp_hs_lines_i),
    .hsa_i       (hsa_bytes_i),
    .hbp_i       (hbp_bytes_i),
    .hact_i      (hact_bytes_i),
    .hfp_i       (hfp_bytes_i),
    .line_len_i  (line_len_i),
    .blank_len_i (blank_len_i),
    .pulse_o     (c_pulse),
    .vcnt_o      (c_vcnt),
    .fp_hs_o     (c_fp_hs),
    .line_len_o  (c_line_len),
    .blank_len_o (c_blank_len),
    .e_sa_o      (c_e_sa),
    .e_se_o      (c_e_se),
    .e_bp_o      (c_e_bp),
    .e_act_o     (c_e_act),
    .e_fp_o      (c_e_fp)
  );

  dsi_seq_vert #(.LINE_W(LINE_W)) u_vert (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (load),
    .start_ph_i (first_ph),
    .adv_i      (adv),
    .vcnt_i     (c_vcnt),
    .vph_o      (vph),
    .vline_o    (vline),
    .line_idx_o (line_idx),
    .last_o     (v_last)
  );

  assign act_line = (vph == VPH_ACT);
  assign lp_line  = c_pulse && (vph == VPH_FRONT) && (vline >= c_fp_hs);

  dsi_seq_hseg #(.BYTE_W(BYTE_W)) u_hseg (
    .run_i      (run_q),
    .pulse_i    (c_pulse),
    .act_line_i (act_line),
    .lp_line_i  (lp_line),
    .byte_i     (byte_q),
    .e_sa_i     (c_e_sa),
    .e_se_i     (c_e_se),
    .e_bp_i     (c_e_bp),
    .e_act_i    (c_e_act),
    .e_fp_i     (c_e_fp),
    .seg_o      (seg)
  );

  assign frame_start_o = fs_q;
  assign line_start_o  = run_q && (byte_q == '0);
  assign sync_start_o  = (seg == SEG_SS);
  assign sync_end_o    = (seg == SEG_SE);
  assign act_o         = (seg == SEG_ACT);
  assign lp_req_o      = (seg == SEG_LP);
  assign seg_o         = seg;
  assign vphase_o      = vph;
  assign line_idx_o    = line_idx;
  assign byte_idx_o    = byte_q;

endmodule

// File: rtl/dsi_line_seq_chk.sv
module dsi_line_seq_chk #(
  parameter int IDX_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_start_o,
  input logic             line_start_o,
  input logic             sync_start_o,
  input logic             sync_end_o,
  input logic             act_o,
  input logic [2:0]       seg_o,
  input logic [1:0]       vphase_o,
  input logic [IDX_W-1:0] line_idx_o
);

  AST_FS_IS_LS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> line_start_o); // R1

  AST_LINE_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |-> (seg_o == 3'd1 || seg_o == 3'd0)); // R3

  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_o && !frame_start_o) |-> (line_idx_o == $past(line_idx_o) + IDX_W'(1))); // R3

  AST_VPH_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_o && !frame_start_o) |-> (vphase_o >= $past(vphase_o))); // R2

  AST_SS_AT_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_start_o |-> line_start_o); // R12

  AST_SE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_end_o |-> ($past(seg_o) == 3'd2 || $past(seg_o) == 3'd1)); // R4

  AST_ACT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_o) |-> ($past(seg_o) == 3'd4 || $past(seg_o) == 3'd3 || $past(seg_o) == 3'd1)); // R5

  AST_ACT_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o |-> (vphase_o == 2'd2)); // R9

endmodule

bind dsi_line_seq dsi_line_seq_chk #(.IDX_W(LINE_W + 2)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_start_o (frame_start_o),
  .line_start_o  (line_start_o),
  .sync_start_o  (sync_start_o),
  .sync_end_o    (sync_end_o),
  .act_o         (act_o),
  .seg_o         (seg_o),
  .vphase_o      (vphase_o),
  .line_idx_o    (line_idx_o)
);

// File: tb/dsi_line_seq_tb.sv
module dsi_line_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LINE_W     = 12;
  localparam int BYTE_W     = 16;
  localparam int NVEC       = 18;

  // {cycle, seg, vphase, line_idx, line_start, frame_start}; pulse frame
  localparam int VEC [NVEC][6] = '{
    '{  0, 1, 0, 0, 1, 1},  // R1 R4 frame head
    '{  1, 2, 0, 0, 0, 0},  // R6 sync-active
    '{  3, 3, 0, 0, 0, 0},  // R6 sync end
    '{  4, 7, 0, 0, 0, 0},  // R6 hs fill
    '{ 13, 7, 0, 0, 0, 0},  // R3 last cycle of blank line
    '{ 14, 1, 1, 1, 1, 0},  // R2 back porch
    '{ 28, 1, 2, 2, 1, 0},  // R3 active line after 2x14
    '{ 33, 4, 2, 2, 0, 0},  // R4 back porch bytes
    '{ 34, 5, 2, 2, 0, 0},  // R4 active start
    '{ 37, 5, 2, 2, 0, 0},  // R4 active end
    '{ 38, 6, 2, 2, 0, 0},  // R4 front porch, R10 after change
    '{ 40, 7, 2, 2, 0, 0},  // R4 tail fill
    '{ 50, 5, 2, 3, 0, 0},  // R3 second active line
    '{ 60, 1, 3, 4, 1, 0},  // R6 hs front-porch line
    '{ 64, 7, 3, 4, 0, 0},  // R6
    '{ 74, 0, 3, 5, 1, 0},  // R7 lp line
    '{101, 0, 3, 6, 0, 0},  // R7 last cycle
    '{102, 1, 0, 0, 1, 1}   // R11 back-to-back frame
  };

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              en_i;
  logic              pulse_mode_i;
  logic [LINE_W-1:0] vsa_lines_i, vbp_lines_i, vact_lines_i, vfp_lines_i, fp_hs_lines_i;
  logic [BYTE_W-1:0] hsa_bytes_i, hbp_bytes_i, hact_bytes_i, hfp_bytes_i;
  logic [BYTE_W-1:0] line_len_i, blank_len_i;
  logic              frame_start_o, line_start_o, sync_start_o, sync_end_o, act_o, lp_req_o;
  logic [2:0]        seg_o;
  logic [1:0]        vphase_o;
  logic [LINE_W+1:0] line_idx_o;
  logic [BYTE_W-1:0] byte_idx_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dsi_line_seq #(.LINE_W(LINE_W), .BYTE_W(BYTE_W)) u_dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .pulse_mode_i  (pulse_mode_i),
    .vsa_lines_i   (vsa_lines_i),
    .vbp_lines_i   (vbp_lines_i),
    .vact_lines_i  (vact_lines_i),
    .vfp_lines_i   (vfp_lines_i),
    .fp_hs_lines_i (fp_hs_lines_i),
    .hsa_bytes_i   (hsa_bytes_i),
    .hbp_bytes_i   (hbp_bytes_i),
    .hact_bytes_i  (hact_bytes_i),
    .hfp_bytes_i   (hfp_bytes_i),
    .line_len_i    (line_len_i),
    .blank_len_i   (blank_len_i),
    .frame_start_o (frame_start_o),
    .line_start_o  (line_start_o),
    .sync_start_o  (sync_start_o),
    .sync_end_o    (sync_end_o),
    .act_o         (act_o),
    .lp_req_o      (lp_req_o),
    .seg_o         (seg_o),
    .vphase_o      (vphase_o),
    .line_idx_o    (line_idx_o),
    .byte_idx_o    (byte_idx_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic set_pulse();
    pulse_mode_i = 1'b1;
    vsa_lines_i = 1; vbp_lines_i = 1; vact_lines_i = 2; vfp_lines_i = 3; fp_hs_lines_i = 1;
    hsa_bytes_i = 2; hbp_bytes_i = 2; hact_bytes_i = 4; hfp_bytes_i = 2;
    line_len_i = 16; blank_len_i = 14;
  endtask

  task automatic set_event();
    pulse_mode_i = 1'b0;
    vsa_lines_i = 1; vbp_lines_i = 0; vact_lines_i = 1; vfp_lines_i = 1; fp_hs_lines_i = 1;
    hsa_bytes_i = 5; hbp_bytes_i = 3; hact_bytes_i = 4; hfp_bytes_i = 2;
    line_len_i = 12; blank_len_i = 10;
  endtask

  task automatic step_to(input int n);
    while (cyc < n) begin
      @(posedge clk_i);
      cyc++;
    end
    @(negedge clk_i);
  endtask

  task automatic check_idle(input string req);
    chk(req, "idle seg", int'(seg_o), 0);
    chk(req, "idle lp_req", int'(lp_req_o), 1);
    chk(req, "idle line_start", int'(line_start_o), 0);
    chk(req, "idle frame_start", int'(frame_start_o), 0);
    chk(req, "idle sync_start", int'(sync_start_o), 0);
  endtask

  task automatic check_point(input string req, input int seg, input int vph, input int idx,
                             input int ls, input int fs);
    chk(req, "seg", int'(seg_o), seg);
    chk("R2", "vphase", int'(vphase_o), vph);
    chk("R3", "line_idx", int'(line_idx_o), idx);
    chk("R3", "line_start", int'(line_start_o), ls);
    chk("R1", "frame_start", int'(frame_start_o), fs);
    chk("R12", "sync_start", int'(sync_start_o), int'(seg == 1));
    chk("R12", "sync_end", int'(sync_end_o), int'(seg == 3));
    chk("R12", "lp_req", int'(lp_req_o), int'(seg == 0));
    chk("R9", "act", int'(act_o), int'(seg == 5));
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    en_i   = 1'b0;
    set_pulse();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check_idle("R1");
    rst_ni = 1'b1;
    repeat (4) begin
      @(negedge clk_i);
      check_idle("R1");
    end

    en_i = 1'b1;
    @(posedge clk_i);
    cyc = 0;
    @(negedge clk_i);

    // pulse frame table; event settings applied mid-frame (R10)
    for (int i = 0; i < NVEC; i++) begin
      if (i > 0) step_to(VEC[i][0]);
      check_point((VEC[i][2] == 2) ? "R4" : ((VEC[i][1] == 0) ? "R7" : "R6"),
                  VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5]);
      if (VEC[i][0] == 13) set_event();
    end

    // event frame starting at 102, settings now in force (R10)
    step_to(103); check_point("R8", 0, 0, 0, 0, 0);   // R8 lp after sync start
    step_to(112); check_point("R5", 1, 2, 1, 1, 0);   // R2 empty back porch skipped
    step_to(113); check_point("R5", 4, 2, 1, 0, 0);   // R5 no sync-active slot
    step_to(116); check_point("R5", 5, 2, 1, 0, 0);
    step_to(119); check_point("R5", 5, 2, 1, 0, 0);
    step_to(120); check_point("R5", 0, 2, 1, 0, 0);   // R5 lp after active data
    en_i = 1'b0;
    step_to(124); check_point("R8", 1, 3, 2, 1, 0);
    step_to(133); check_point("R8", 0, 3, 2, 0, 0);

    // R11 stop at frame end, then restart
    step_to(134); check_idle("R11");
    step_to(140); check_idle("R11");
    en_i = 1'b1;
    step_to(141); check_point("R11", 1, 0, 0, 1, 1);
    step_to(142); check_point("R11", 0, 0, 0, 0, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule